// File: doc/BRIEF.md
# Port-Read Response Sequencer

This block finishes an input-port read for a processor whose I/O request strobe cannot be seen from outside. An upstream tracker marks each instruction fetch with a one-cycle pulse and hands over the fetched opcode together with the byte that follows it in memory. When that opcode is the "read port into accumulator" instruction (0xDB), the sequencer latches the following byte as the port number and asks a peripheral for the value at that port. It stores the returned byte and publishes it as a write into the tracker's shadow copy of the accumulator.

The processor must see the byte on its data bus during the I/O cycle, and that cycle cannot be observed. The sequencer therefore times the drive from two other events. It waits until the tracker's instruction-length skip counter reports zero, and then it holds the byte on the bus. It lets go of the bus when the memory-request strobe next becomes active, which marks the start of the following fetch. While it is driving, it tells the tracker to stop decoding fetches.

Top module: `in_read_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_oe`, `rd_req`, `shadow_a_we` and `decode_hold` are 0 and `bus_dout` is 0.
- R2: If `fetch_pulse` is 1 with `fetch_opcode` = 0xDB while the block is idle, `rd_req` is 1 from the next cycle. `rd_port` then equals the `fetch_operand` value sampled at that fetch.
- R3: A fetch pulse with any opcode other than 0xDB, or the value 0xDB without a fetch pulse, starts no request and no bus drive.
- R4: `rd_req` stays at 1 until a cycle in which `rsp_valid` is 1. That cycle accepts the response, and from the next cycle `rd_req` is 0.
- R5: `shadow_a_we` is 1 only in the acceptance cycle, and `shadow_a_val` equals `rsp_data` in that cycle.
- R6: `bus_oe` becomes 1 in the cycle after the first cycle in which the response has been accepted (before or in that cycle) and `skip_zero` is 1.
- R7: If `skip_zero` is 1 before any response has arrived, the block keeps waiting and does not drive the bus.
- R8: While `bus_oe` is 1, `bus_dout` holds the accepted byte and `decode_hold` is 1. A fetch pulse carrying 0xDB in this state starts no new request.
- R9: While driving, a 0-to-1 change of `mreq_active` makes `bus_oe` 0 from the next cycle. If `mreq_active` is already 1 when driving begins, the bus stays driven until the strobe falls and rises again.
- R10: `bus_oe` and `decode_hold` are 0 in every state except driving, and `bus_dout` is 0 whenever `bus_oe` is 0.
- R11: A change of `fetch_operand` after the triggering fetch does not change `rd_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pulse | input | 1 | One-cycle marker of an instruction fetch |
| fetch_opcode | input | OPC_W | Opcode byte of that fetch |
| fetch_operand | input | PORT_W | Byte at fetch address plus one |
| skip_zero | input | 1 | Tracker's skip counter has reached zero |
| mreq_active | input | 1 | Memory-request strobe, active high |
| rd_req | output | 1 | Peripheral read request, held until answered |
| rd_port | output | PORT_W | Port number of the request |
| rsp_valid | input | 1 | Peripheral response valid |
| rsp_data | input | DATA_W | Peripheral response byte |
| bus_oe | output | 1 | Data-bus drive enable |
| bus_dout | output | DATA_W | Byte driven on the data bus |
| shadow_a_we | output | 1 | Write strobe for the shadow accumulator |
| shadow_a_val | output | DATA_W | Value for the shadow accumulator |
| decode_hold | output | 1 | Suppress fetch decoding while driving |

## Verification
The bench goes through every opcode value to find a decoder that fires on the wrong code or with no fetch pulse present. It crosses four response latencies with four skip-zero delays and several data bytes. A design that drives before the data arrives, drives one cycle late, or drops the request before or after the acceptance cycle then shows up as a wrong `bus_oe` or `rd_req` in a specific cycle. The operand is corrupted after each trigger to catch a port that is not latched. A 0xDB fetch is injected while the bus is driven to catch a decoder that is not suppressed. One case holds the memory-request strobe high across the entry to driving. A design that releases on the level of the strobe instead of its rising edge would free the bus at once in that case.

// File: rtl/insq_pkg.sv
package insq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PEND  = 2'd1,
        SQ_DRIVE = 2'd2
    } sq_state_e;
endpackage

// File: rtl/insq_opcode_match.sv
module insq_opcode_match #(
    parameter int             OPC_W = 8,
    parameter logic [OPC_W-1:0] CODE  = 8'hDB
) (
    input  logic             strobe,
    input  logic             enable,
    input  logic [OPC_W-1:0] opcode,
    output logic             hit
);
    always_comb begin
        hit = strobe && enable && (opcode == CODE);
    end
endmodule

// File: rtl/insq_rise_det.sv
module insq_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q, prev_d;

    always_comb begin
        prev_d = level;
        rise   = level && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/in_read_sequencer.sv
module in_read_sequencer
    import insq_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               PORT_W = 8,
    parameter int               OPC_W  = 8,
    parameter logic [OPC_W-1:0] IN_OPC = 8'hDB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_pulse,
    input  logic [OPC_W-1:0]  fetch_opcode,
    input  logic [PORT_W-1:0] fetch_operand,
    input  logic              skip_zero,
    input  logic              mreq_active,
    output logic              rd_req,
    output logic [PORT_W-1:0] rd_port,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              shadow_a_we,
    output logic [DATA_W-1:0] shadow_a_val,
    output logic              decode_hold
);
    typedef struct packed {
        sq_state_e         st;
        logic [PORT_W-1:0] port;
        logic [DATA_W-1:0] resp;
        logic              have;
    } sq_regs_t;

    localparam sq_regs_t REGS_RST = '{st: SQ_IDLE, port: '0, resp: '0, have: 1'b0};

    sq_regs_t r_q, r_d;
    logic     start_hit;
    logic     mreq_rise;
    logic     accept;

    insq_opcode_match #(.OPC_W(OPC_W), .CODE(IN_OPC)) u_match (
        .strobe (fetch_pulse),
        .enable (r_q.st == SQ_IDLE),
        .opcode (fetch_opcode),
        .hit    (start_hit)
    );

    insq_rise_det u_mreq_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (mreq_active),
        .rise  (mreq_rise)
    );

    always_comb begin
        r_d    = r_q;
        rd_req = (r_q.st == SQ_PEND) && !r_q.have;
        accept = rd_req && rsp_valid;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (start_hit) begin
                    r_d.st   = SQ_PEND;
                    r_d.port = fetch_operand;
                    r_d.have = 1'b0;
                end
            end
            SQ_PEND: begin
                if (accept) begin
                    r_d.resp = rsp_data;
                    r_d.have = 1'b1;
                end
                if ((r_q.have || accept) && skip_zero) begin
                    r_d.st = SQ_DRIVE;
                end
            end
            SQ_DRIVE: begin
                if (mreq_rise) begin
                    r_d.st   = SQ_IDLE;
                    r_d.have = 1'b0;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_port      = r_q.port;
        bus_oe       = (r_q.st == SQ_DRIVE);
        bus_dout     = bus_oe ? r_q.resp : '0;
        decode_hold  = bus_oe;
        shadow_a_we  = accept;
        shadow_a_val = rsp_data;
    end

    p_req_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe && !rd_req && r_q.st == SQ_IDLE && fetch_pulse && fetch_opcode == IN_OPC)
        |=> (rd_req && rd_port == $past(fetch_operand)));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rsp_valid) |=> rd_req);

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rsp_valid) |=> !rd_req);

    p_shadow_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_a_we |=> !shadow_a_we);

    p_drive_needs_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(skip_zero));

    p_no_drive_while_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !bus_oe);

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && mreq_rise) |=> !bus_oe);

    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0 && !decode_hold));
endmodule

// File: tb/tb_in_read_sequencer.sv
module tb_in_read_sequencer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fetch_pulse, skip_zero, mreq_active, rsp_valid;
    logic [7:0] fetch_opcode, fetch_operand, rsp_data;
    logic       rd_req, bus_oe, shadow_a_we, decode_hold;
    logic [7:0] rd_port, bus_dout, shadow_a_val;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    in_read_sequencer dut (
        .clk(clk), .rst_n(rst_n), .fetch_pulse(fetch_pulse), .fetch_opcode(fetch_opcode),
        .fetch_operand(fetch_operand), .skip_zero(skip_zero), .mreq_active(mreq_active),
        .rd_req(rd_req), .rd_port(rd_port), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .shadow_a_we(shadow_a_we),
        .shadow_a_val(shadow_a_val), .decode_hold(decode_hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_inputs();
        fetch_pulse = 0; fetch_opcode = 8'h00; fetch_operand = 8'h00;
        skip_zero = 0; mreq_active = 0; rsp_valid = 0; rsp_data = 8'h00;
    endtask

    // One port read: response after lat cycles, skip_zero after skd cycles
    task automatic run_in(input int lat, input int skd, input logic [7:0] port,
                          input logic [7:0] data);
        bit acc;
        int last;
        last = (lat > skd) ? lat : skd;
        acc  = 0;
        next_cyc();
        idle_inputs();
        fetch_pulse = 1; fetch_opcode = 8'hDB; fetch_operand = port;
        settle();
        chk(!rd_req && !bus_oe, "R2 no request in fetch cycle", rd_req, 0);
        for (int k = 0; k <= last; k++) begin
            next_cyc();
            fetch_pulse = 0; fetch_operand = ~port;
            rsp_valid = (k >= lat) && !acc;
            rsp_data  = data;
            skip_zero = (k >= skd);
            settle();
            chk(rd_req == !acc, "R4 request held", rd_req, !acc);
            chk(rd_port == port, "R2 R11 port latched", rd_port, port);
            chk(!bus_oe && !decode_hold, "R7 R10 no drive while pending", bus_oe, 0);
            if (rsp_valid && rd_req) begin
                chk(shadow_a_we && shadow_a_val == data, "R5 shadow write", shadow_a_val, data);
                acc = 1;
            end else begin
                chk(!shadow_a_we, "R5 no shadow write", shadow_a_we, 0);
            end
        end
        next_cyc();
        rsp_valid = 0; skip_zero = 0;
        fetch_pulse = 1; fetch_opcode = 8'hDB;
        settle();
        chk(bus_oe, "R6 drive begins", bus_oe, 1);
        chk(bus_dout == data, "R8 data on bus", bus_dout, data);
        chk(decode_hold, "R8 decode held", decode_hold, 1);
        chk(!rd_req, "R4 request dropped", rd_req, 0);
        next_cyc();
        fetch_pulse = 0;
        mreq_active = 1;
        settle();
        chk(!rd_req && bus_oe && bus_dout == data, "R8 fetch ignored while driving", bus_dout, data);
        next_cyc();
        mreq_active = 0;
        settle();
        chk(!bus_oe && bus_dout == 8'h00 && !rd_req, "R9 R10 released", bus_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) next_cyc();
        settle();
        chk(!bus_oe && !rd_req && !shadow_a_we && !decode_hold && bus_dout == 0,
            "R1 in reset", bus_oe, 0);
        next_cyc();
        rst_n = 1;
        settle();
        chk(!bus_oe && !rd_req && bus_dout == 0, "R1 after reset", bus_oe, 0);

        // R3: every opcode except the read-port code, with pulse
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hDB) begin
                next_cyc();
                fetch_pulse = 1; fetch_opcode = 8'(op); fetch_operand = 8'(op);
                next_cyc();
                fetch_pulse = 0;
                settle();
                chk(!rd_req && !bus_oe, "R3 other opcode ignored", rd_req, 0);
            end
        end
        next_cyc();
        fetch_pulse = 0; fetch_opcode = 8'hDB;
        next_cyc();
        settle();
        chk(!rd_req && !bus_oe, "R3 opcode without pulse", rd_req, 0);

        for (int lat = 0; lat < 4; lat++)
            for (int skd = 0; skd < 4; skd++)
                for (int dv = 0; dv < 4; dv++)
                    run_in(lat, skd, 8'((lat * 16 + skd * 4 + dv) ^ 8'h5A),
                           8'(dv * 85 + lat * 7 + skd));

        // R9: strobe already high when driving begins
        next_cyc();
        idle_inputs();
        fetch_pulse = 1; fetch_opcode = 8'hDB; fetch_operand = 8'h42;
        next_cyc();
        fetch_pulse = 0; mreq_active = 1; rsp_valid = 1; rsp_data = 8'hC3; skip_zero = 1;
        next_cyc();
        rsp_valid = 0; skip_zero = 0;
        settle();
        chk(bus_oe && bus_dout == 8'hC3, "R9 drive with strobe high", bus_dout, 8'hC3);
        next_cyc();
        settle();
        chk(bus_oe, "R9 level does not release", bus_oe, 1);
        next_cyc();
        mreq_active = 0;
        next_cyc();
        settle();
        chk(bus_oe, "R9 still driving after fall", bus_oe, 1);
        mreq_active = 1;
        next_cyc();
        settle();
        chk(!bus_oe && bus_dout == 0, "R9 released on rise", bus_oe, 0);
        mreq_active = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule